// File: doc/BRIEF.md
# Power-Up Write-Inhibit Sequencer

This block sits between the supply monitors and the command logic of a serial NOR flash. It decides, cycle by cycle, whether the command logic is held in reset, whether read instructions may run, and whether write-enable and modify instructions (status write, program, erase) may run. Its inputs are two synchronous comparator flags. One reports that the supply is above the write-inhibit threshold. The other reports that the supply is above the minimum operating level.

Two delay counters set the timing, each with a cycle count given as a parameter. The write delay starts when the supply passes the write-inhibit threshold. The read delay starts when the supply passes the minimum operating level. Reads open as soon as the read delay ends. Write-enable and modify instructions open only when both delays have ended.

The command decoder presents one instruction class per cycle. The block answers with a one-cycle accept pulse or a one-cycle ignore pulse. On the first cycle out of internal reset it raises a load strobe. Along with the strobe it supplies the values that the status and lock bits must take.

Top module: `pwrup_inhibit_seq`

## Requirements
- R1: While `rst` is high or `above_vwi` is low, `core_rst` is high and both `read_ok` and `modify_ok` are low, so every instruction is refused.
- R2: `modify_ok` rises only after `PUW_CYC` consecutive clock edges with `above_vwi` high. It is low after `PUW_CYC-1` such edges.
- R3: `read_ok` rises after `VSL_CYC` consecutive edges with both `above_vwi` and `above_vmin` high, whether or not the write delay has ended.
- R4: `modify_ok` needs both delays to have ended, so it follows the later of the two. Whenever `modify_ok` is high, `read_ok` is high.
- R5: `init_load` is high for exactly the first cycle after `core_rst` falls. `init_bits` carries the reset values at all times: bit0 write-enable latch = 0, bit1 write-in-progress = 0, bit2 lock write bit = 0, bit3 lock-down bit = 0, bit4 power mode = 0 (standby; 1 would mean deep power-down).
- R6: When `above_vwi` falls, `core_rst` rises and both gates drop in that same cycle, with no clock edge in between.
- R7: When `above_vmin` falls, `read_ok` and `modify_ok` drop at once. After it returns, the read delay counts again from zero.
- R8: If `above_vwi` falls before the write delay has ended, the write delay counts again from zero after it returns.
- R9: Command class encoding: 0 none, 1 read, 2 write-enable, 3 modify. A `cmd_valid` cycle with a nonzero class produces one of two pulses, each lasting exactly one cycle after the sampling edge. If the class is permitted in that cycle, the pulse is `cmd_accept`; otherwise it is `cmd_ignored`. Class 0 produces neither pulse.
- R10: A refused command leaves `read_ok` and `modify_ok` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| above_vwi | input | 1 | Supply above the write-inhibit threshold (synchronous) |
| above_vmin | input | 1 | Supply above the minimum operating level (synchronous) |
| cmd_valid | input | 1 | Instruction class presented this cycle |
| cmd_class | input | 2 | Instruction class: 0 none, 1 read, 2 write-enable, 3 modify |
| core_rst | output | 1 | Reset for the command logic |
| read_ok | output | 1 | Read instructions permitted |
| modify_ok | output | 1 | Write-enable and modify instructions permitted |
| cmd_accept | output | 1 | One-cycle pulse for a permitted instruction |
| cmd_ignored | output | 1 | One-cycle pulse for a refused instruction |
| init_load | output | 1 | Strobe to load status and lock bits, first cycle out of reset |
| init_bits | output | 5 | Values to load: {mode, lock-down, lock write, WIP, WEL} |

## Verification
Some results settle combinationally in the cycle of the stimulus: `core_rst`, the withdrawal of the two gates, and the first `init_load` cycle. Others need clock edges. A gate opens after the stated number of edges with its supply flag high. The accept and ignore pulses appear one edge after the command is sampled. The bench drives inputs on the falling edge and samples 1 ns later. At that point the combinational results reflect the new inputs, and the registered results reflect every rising edge counted so far. Each delay is checked one cycle before, at, and one cycle after expiry. Each pulse is checked both in its own cycle and in the cycle after.

// File: rtl/pwrup_pkg.sv
`timescale 1ns/1ps
package pwrup_pkg;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_READ   = 2'd1,
        CLS_WREN   = 2'd2,
        CLS_MODIFY = 2'd3
    } cmd_class_e;

    typedef enum logic {
        MODE_STANDBY = 1'b0,
        MODE_DEEP_PD = 1'b1
    } pwr_mode_e;

    // bit4 mode, bit3 lock-down, bit2 lock write, bit1 WIP, bit0 WEL
    typedef struct packed {
        pwr_mode_e mode;
        logic      lock_dn;
        logic      lock_wr;
        logic      wip;
        logic      wel;
    } init_bits_t;

    localparam init_bits_t INIT_DEFAULTS = '{
        mode:    MODE_STANDBY,
        lock_dn: 1'b0,
        lock_wr: 1'b0,
        wip:     1'b0,
        wel:     1'b0
    };

    function automatic logic needs_modify(cmd_class_e c);
        return (c == CLS_WREN) || (c == CLS_MODIFY);
    endfunction

endpackage

// File: rtl/pwrup_delay_timer.sv
`timescale 1ns/1ps
module pwrup_delay_timer #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic done
);
    localparam int W = $clog2(CYC + 1);
    localparam logic [W-1:0] LIMIT = W'(CYC);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIMIT);

    // R7 / R8: a low enable always restarts the delay
    assert_restart_on_drop_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !done);

    // R2 / R3: the count never passes its limit
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);
endmodule

// File: rtl/pwrup_gate.sv
`timescale 1ns/1ps
module pwrup_gate
    import pwrup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       above_vwi,
    input  logic       above_vmin,
    input  logic       puw_done,
    input  logic       vsl_done,
    output logic       core_rst,
    output logic       read_ok,
    output logic       modify_ok,
    output logic       init_load,
    output init_bits_t init_bits
);
    logic core_rst_d;

    always_comb begin
        core_rst  = rst || !above_vwi;
        read_ok   = !core_rst && above_vmin && vsl_done;
        modify_ok = read_ok && puw_done;
        init_bits = INIT_DEFAULTS;
    end

    always_ff @(posedge clk) begin
        if (rst) core_rst_d <= 1'b1;
        else     core_rst_d <= core_rst;
    end

    assign init_load = core_rst_d && !core_rst;

    assert_strobe_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        init_load |=> !init_load);

    assert_strobe_outside_reset_R5: assert property (@(posedge clk) disable iff (rst)
        init_load |-> !core_rst);
endmodule

// File: rtl/pwrup_cmd_filter.sv
`timescale 1ns/1ps
module pwrup_cmd_filter
    import pwrup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  cmd_class_e cmd_class,
    input  logic       read_ok,
    input  logic       modify_ok,
    output logic       cmd_accept,
    output logic       cmd_ignored
);
    logic grant, refuse;

    always_comb begin
        grant = 1'b0;
        if (cmd_valid) begin
            if (cmd_class == CLS_READ)        grant = read_ok;
            else if (needs_modify(cmd_class)) grant = modify_ok;
        end
        refuse = cmd_valid && (cmd_class != CLS_NONE) && !grant;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_accept  <= 1'b0;
            cmd_ignored <= 1'b0;
        end else begin
            cmd_accept  <= grant;
            cmd_ignored <= refuse;
        end
    end

    assert_exclusive_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        !(cmd_accept && cmd_ignored));
endmodule

// File: rtl/pwrup_inhibit_seq.sv
`timescale 1ns/1ps
module pwrup_inhibit_seq
    import pwrup_pkg::*;
#(
    parameter int PUW_CYC = 64,
    parameter int VSL_CYC = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       above_vwi,
    input  logic       above_vmin,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_class,
    output logic       core_rst,
    output logic       read_ok,
    output logic       modify_ok,
    output logic       cmd_accept,
    output logic       cmd_ignored,
    output logic       init_load,
    output logic [4:0] init_bits
);
    logic       puw_done, vsl_done;
    init_bits_t init_s;

    pwrup_delay_timer #(.CYC(PUW_CYC)) i_puw_timer (
        .clk (clk),
        .rst (rst),
        .en  (above_vwi),
        .done(puw_done)
    );

    pwrup_delay_timer #(.CYC(VSL_CYC)) i_vsl_timer (
        .clk (clk),
        .rst (rst),
        .en  (above_vwi && above_vmin),
        .done(vsl_done)
    );

    pwrup_gate i_gate (
        .clk       (clk),
        .rst       (rst),
        .above_vwi (above_vwi),
        .above_vmin(above_vmin),
        .puw_done  (puw_done),
        .vsl_done  (vsl_done),
        .core_rst  (core_rst),
        .read_ok   (read_ok),
        .modify_ok (modify_ok),
        .init_load (init_load),
        .init_bits (init_s)
    );

    pwrup_cmd_filter i_filter (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_class  (cmd_class_e'(cmd_class)),
        .read_ok    (read_ok),
        .modify_ok  (modify_ok),
        .cmd_accept (cmd_accept),
        .cmd_ignored(cmd_ignored)
    );

    assign init_bits = init_s;

    assert_held_below_vwi_R1: assert property (@(posedge clk) disable iff (rst)
        !above_vwi |-> (core_rst && !read_ok && !modify_ok));

    assert_modify_implies_read_R4: assert property (@(posedge clk) disable iff (rst)
        modify_ok |-> read_ok);

    assert_vmin_restart_R7: assert property (@(posedge clk) disable iff (rst)
        !above_vmin |=> !read_ok);

    assert_refused_read_flagged_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_class == 2'd1 && !read_ok) |=> cmd_ignored);

    assert_refused_modify_flagged_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_class[1] && !modify_ok) |=> (cmd_ignored && !cmd_accept));
endmodule

// File: tb/test_pwrup_inhibit_seq.sv
`timescale 1ns/1ps
module test_pwrup_inhibit_seq;
    localparam int PUW = 10;
    localparam int VSL = 6;

    logic       clk = 1'b0;
    logic       rst, above_vwi, above_vmin, cmd_valid;
    logic [1:0] cmd_class;
    logic       core_rst, read_ok, modify_ok, cmd_accept, cmd_ignored, init_load;
    logic [4:0] init_bits;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pwrup_inhibit_seq #(.PUW_CYC(PUW), .VSL_CYC(VSL)) i_pwrup_inhibit_seq (
        .clk(clk), .rst(rst), .above_vwi(above_vwi), .above_vmin(above_vmin),
        .cmd_valid(cmd_valid), .cmd_class(cmd_class), .core_rst(core_rst),
        .read_ok(read_ok), .modify_ok(modify_ok), .cmd_accept(cmd_accept),
        .cmd_ignored(cmd_ignored), .init_load(init_load), .init_bits(init_bits)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // advance to the next falling edge, then settle
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic power_off();
        @(negedge clk);
        above_vwi = 0; above_vmin = 0; cmd_valid = 0; cmd_class = 0;
        repeat (2) step();
    endtask

    task automatic power_full();
        power_off();
        @(negedge clk);
        above_vwi = 1; above_vmin = 1;
        repeat (PUW + 2) step();
    endtask

    // issue one command; returns pulses seen one edge later
    task automatic issue(input logic [1:0] cls, output logic acc, output logic ign);
        @(negedge clk);
        cmd_valid = 1; cmd_class = cls;
        step();
        cmd_valid = 0; cmd_class = 0;
        #0.5;
        acc = cmd_accept; ign = cmd_ignored;
    endtask

    task automatic t_reset();
        logic acc, ign;
        rst = 1; above_vwi = 0; above_vmin = 0; cmd_valid = 0; cmd_class = 0;
        repeat (3) step();
        chk("R1", "core_rst in reset", core_rst, 1);
        chk("R1", "read_ok in reset", read_ok, 0);
        chk("R1", "modify_ok in reset", modify_ok, 0);
        chk("R5", "init_load in reset", init_load, 0);
        @(negedge clk); rst = 0;
        repeat (3) step();
        chk("R1", "core_rst below vwi", core_rst, 1);
        issue(2'd1, acc, ign);
        chk("R1", "read ignored below vwi", ign, 1);
        chk("R1", "read not accepted below vwi", acc, 0);
    endtask

    task automatic t_powerup_edges();
        power_off();
        @(negedge clk);
        above_vwi = 1; above_vmin = 1;
        #1;
        chk("R5", "init_load first cycle", init_load, 1);
        chk("R5", "init_bits values", init_bits, 0);
        chk("R1", "core_rst released", core_rst, 0);
        for (int k = 1; k <= PUW + 1; k++) begin
            step();
            if (k == 1) chk("R5", "init_load one cycle only", init_load, 0);
            if (k >= VSL - 1 && k <= VSL + 1)
                chk("R3", $sformatf("read_ok after %0d edges", k), read_ok, int'(k >= VSL));
            if (k >= PUW - 1 && k <= PUW + 1)
                chk("R2", $sformatf("modify_ok after %0d edges", k), modify_ok, int'(k >= PUW));
        end
    endtask

    task automatic t_read_before_modify();
        logic acc, ign;
        power_off();
        @(negedge clk);
        above_vwi = 1; above_vmin = 1;
        repeat (VSL) step();
        chk("R3", "read open ahead of modify", read_ok, 1);
        chk("R2", "modify still closed", modify_ok, 0);
        issue(2'd2, acc, ign);
        chk("R9", "write-enable ignored pulse", ign, 1);
        chk("R9", "write-enable not accepted", acc, 0);
        chk("R10", "read_ok unchanged after refusal", read_ok, 1);
        step();
        chk("R9", "ignored pulse ends", cmd_ignored, 0);
        issue(2'd1, acc, ign);
        chk("R9", "read accepted", acc, 1);
        chk("R9", "read not ignored", ign, 0);
        issue(2'd0, acc, ign);
        chk("R9", "class none no accept", acc, 0);
        chk("R9", "class none no ignore", ign, 0);
    endtask

    task automatic t_late_vmin();
        logic acc, ign;
        power_off();
        @(negedge clk);
        above_vwi = 1;
        repeat (8) step();
        above_vmin = 1;
        for (int k = 9; k <= 8 + VSL + 1; k++) begin
            step();
            if (k >= 8 + VSL - 1) begin
                chk("R4", $sformatf("read_ok at %0d", k), read_ok, int'(k >= 8 + VSL));
                chk("R4", $sformatf("modify_ok at %0d", k), modify_ok, int'(k >= 8 + VSL));
            end
        end
        issue(2'd3, acc, ign);
        chk("R4", "modify accepted after both delays", acc, 1);
    endtask

    task automatic t_vmin_drop();
        power_full();
        chk("R7", "fully up modify", modify_ok, 1);
        @(negedge clk); above_vmin = 0; #1;
        chk("R7", "read drops at once", read_ok, 0);
        chk("R7", "modify drops at once", modify_ok, 0);
        chk("R7", "core_rst stays low", core_rst, 0);
        @(negedge clk); above_vmin = 1;
        for (int k = 1; k <= VSL; k++) begin
            step();
            if (k >= VSL - 1) begin
                chk("R7", $sformatf("read_ok after restart %0d", k), read_ok, int'(k >= VSL));
                chk("R7", $sformatf("modify_ok after restart %0d", k), modify_ok, int'(k >= VSL));
            end
        end
    endtask

    task automatic t_vwi_drop();
        logic acc, ign;
        power_full();
        @(negedge clk); above_vwi = 0; #1;
        chk("R6", "core_rst rises at once", core_rst, 1);
        chk("R6", "read drops at once", read_ok, 0);
        chk("R6", "modify drops at once", modify_ok, 0);
        issue(2'd3, acc, ign);
        chk("R1", "modify ignored after drop", ign, 1);
        // partial write delay, then a one-cycle dip
        @(negedge clk); above_vwi = 1;
        repeat (5) step();
        above_vwi = 0;
        step();
        above_vwi = 1;
        for (int k = 1; k <= PUW; k++) begin
            step();
            if (k == 5) chk("R8", "no carry-over of old count", modify_ok, 0);
            if (k >= PUW - 1)
                chk("R8", $sformatf("modify_ok after restart %0d", k), modify_ok, int'(k >= PUW));
        end
    endtask

    initial begin
        #(100000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_powerup_edges();
        t_read_before_modify();
        t_late_vmin();
        t_vmin_drop();
        t_vwi_drop();
        chk("R5", "init_bits constant", init_bits, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule